// File: doc/BRIEF.md
# Multi-Timer Unit with Prescaler

This block holds four independent down-counting timers behind a flat 32-bit register window. Two timers are 16 bits wide and two are 32 bits wide. One packed control/status word gives each timer its own byte lane. The lane holds an expiry flag, a run enable, an interrupt enable and a two-bit rate code. Each timer has a reload register and a read-only count register.

The block runs from a single 4 MHz reference clock. A free-running divider makes single-cycle tick strobes at 2 MHz, 1 MHz, 500 kHz and 250 kHz, and each timer takes the strobe chosen by its rate code. An enabled timer steps its count down once per selected tick. On the tick where the count is already zero, the timer reloads and raises its expiry flag, so it runs periodically.

Software can poll the expiry flags, or it can rely on the shared interrupt line. The line stays high while any flag is set whose interrupt enable is also set.

Top module: `tmr_bank`

## Requirements
- R1: After reset the control/status word (byte offset 0x00) reads 0, every count and reload register reads 0, and `irq` is low.
- R2: In the control/status word, timer n (0..3) owns bits [8n+4:8n]. The fields are: bit 8n is the expiry flag, bit 8n+1 is the run enable, bit 8n+2 is the interrupt enable, and bits 8n+4:8n+3 are the rate code. Enable, interrupt enable and rate code read back as written. All other bits read as 0.
- R3: With the clock at 4 MHz, rate code 0 steps a running timer every 2 clock cycles, code 1 every 4, code 2 every 8 and code 3 every 16.
- R4: A timer whose run enable is 0 holds its count.
- R5: Writing a reload value R loads both the reload register and the count. A running timer decrements on each selected tick. On a tick at count 0 it reloads R and sets its expiry flag, which gives a period of R+1 ticks.
- R6: Writing 1 to an expiry flag bit clears it, and writing 0 leaves it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R7: `irq` goes high one cycle after any timer has both its expiry flag and its interrupt enable set, and stays high until no such pair remains. A flag with its interrupt enable at 0 does not raise `irq`.
- R8: Timer n has its reload register at byte offset 0x04+8n and its count register at 0x08+8n. Writes to a count register are ignored.
- R9: Timers 0 and 1 are 16 bits wide. They ignore bits 31:16 on writes and read those bits as 0. Timers 2 and 3 keep all 32 bits.
- R10: `bus_rdata` is registered and shows the register addressed by `bus_addr` one clock cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, OR of enabled expiry flags |

## Verification
The bench builds the block with its default parameters: 32-bit data, 6-bit byte addresses, and narrow and wide timers of 16 and 32 bits. This exercises both the upper-halfword masking of the narrow timers and the full-width path of the wide ones. Small reload values such as 3 and 5 at the fastest rate bring wrap-around and expiry within a few dozen cycles. A large reload on a wide timer keeps the count away from zero, so the step interval of each of the four rate codes can be measured cleanly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_TMR   = 4;
  localparam int LANE_W    = 8;
  localparam int RATE_W    = 2;
  localparam int NUM_RATES = 1 << RATE_W;

  localparam int FLD_FLAG  = 0;
  localparam int FLD_RUN   = 1;
  localparam int FLD_IEN   = 2;
  localparam int FLD_RATE  = 3;

  localparam int NUM_NARROW = 2;

  function automatic int chan_width(input int idx, input int narrow_w, input int wide_w);
    return (idx < NUM_NARROW) ? narrow_w : wide_w;
  endfunction

  function automatic int reload_offset(input int idx);
    return 4 + 8 * idx;
  endfunction

  function automatic int count_offset(input int idx);
    return 8 + 8 * idx;
  endfunction
endpackage

// File: rtl/tmr_rate_gen.sv
module tmr_rate_gen #(
  parameter int NUM_RATES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [NUM_RATES-1:0] tick
);
  localparam int DIV_W = NUM_RATES;

  logic [DIV_W-1:0]     div_q;
  logic [NUM_RATES-1:0] tick_d;

  always_comb begin
    for (int k = 0; k < NUM_RATES; k++) begin
      logic [DIV_W-1:0] mask;
      mask      = DIV_W'((1 << (k + 1)) - 1);
      tick_d[k] = ((div_q & mask) == mask);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      tick  <= '0;
    end else begin
      div_q <= div_q + 1'b1;
      tick  <= tick_d;
    end
  end

  AST_FAST_TICK_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    tick[0] |=> !tick[0]); // R3

  AST_SLOW_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick[NUM_RATES-1] |=> !tick[NUM_RATES-1]); // R3

  generate
    for (genvar k = 1; k < NUM_RATES; k++) begin : g_nest
      AST_TICK_NESTED: assert property (@(posedge clk) disable iff (rst)
        tick[k] |-> tick[k-1]); // R3
    end
  endgenerate
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             expire
);
  logic at_zero;

  assign at_zero = (count == '0);
  assign expire  = run && tick && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      reload <= '0;
    end else if (load) begin
      reload <= load_val;
      count  <= load_val;
    end else if (run && tick) begin
      count <= at_zero ? reload : count - 1'b1;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(count)); // R4

  AST_RELOAD_AFTER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (expire && !load) |=> (count == $past(reload))); // R5

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !load && !at_zero) |=> (count == $past(count) - 1'b1)); // R5

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(load_val) && reload == $past(load_val))); // R5
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CTRL_ADDR = 0;

  logic [NUM_RATES-1:0]             tick;
  logic [NUM_TMR-1:0]               run_q;
  logic [NUM_TMR-1:0]               ien_q;
  logic [NUM_TMR-1:0]               flag_q;
  logic [NUM_TMR-1:0][RATE_W-1:0]   rate_q;
  logic [NUM_TMR-1:0]               expire;
  logic [DATA_W-1:0]                cnt_word [NUM_TMR];
  logic [DATA_W-1:0]                rld_word [NUM_TMR];
  logic [DATA_W-1:0]                ctrl_word;
  logic [DATA_W-1:0]                rd_d;
  logic                             ctrl_wr;

  assign ctrl_wr = bus_we && (bus_addr == ADDR_W'(CTRL_ADDR));

  tmr_rate_gen #(.NUM_RATES(NUM_RATES)) i_rate_gen (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  generate
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chan
      localparam int W = chan_width(i, NARROW_W, WIDE_W);
      localparam logic [ADDR_W-1:0] RLD_A = ADDR_W'(reload_offset(i));
      localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(count_offset(i));

      logic [W-1:0] cnt_w;
      logic [W-1:0] rld_w;
      logic         load;

      assign load = bus_we && (bus_addr == RLD_A);

      tmr_channel #(.CNT_W(W)) i_chan (
        .clk      (clk),
        .rst      (rst),
        .run      (run_q[i]),
        .tick     (tick[rate_q[i]]),
        .load     (load),
        .load_val (bus_wdata[W-1:0]),
        .count    (cnt_w),
        .reload   (rld_w),
        .expire   (expire[i])
      );

      assign cnt_word[i] = DATA_W'(cnt_w);
      assign rld_word[i] = DATA_W'(rld_w);

      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q[i] && !(ctrl_wr && bus_wdata[LANE_W*i + FLD_FLAG])) |=> flag_q[i]); // R6

      AST_EXPIRE_WINS: assert property (@(posedge clk) disable iff (rst)
        expire[i] |=> flag_q[i]); // R6

      if (W < DATA_W) begin : g_narrow_chk
        AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
          (bus_addr == RLD_A || bus_addr == CNT_A) |=> (bus_rdata[DATA_W-1:W] == '0)); // R9
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      ien_q  <= '0;
      flag_q <= '0;
      rate_q <= '0;
      irq    <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_TMR; i++) begin
        if (ctrl_wr) begin
          run_q[i]  <= bus_wdata[LANE_W*i + FLD_RUN];
          ien_q[i]  <= bus_wdata[LANE_W*i + FLD_IEN];
          rate_q[i] <= bus_wdata[LANE_W*i + FLD_RATE +: RATE_W];
        end
        flag_q[i] <= (flag_q[i] && !(ctrl_wr && bus_wdata[LANE_W*i + FLD_FLAG])) || expire[i];
      end
      irq <= |(flag_q & ien_q);
    end
  end

  always_comb begin
    ctrl_word = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      ctrl_word[LANE_W*i + FLD_FLAG]          = flag_q[i];
      ctrl_word[LANE_W*i + FLD_RUN]           = run_q[i];
      ctrl_word[LANE_W*i + FLD_IEN]           = ien_q[i];
      ctrl_word[LANE_W*i + FLD_RATE +: RATE_W] = rate_q[i];
    end
  end

  always_comb begin
    rd_d = '0;
    if (bus_addr == ADDR_W'(CTRL_ADDR)) rd_d = ctrl_word;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (bus_addr == ADDR_W'(reload_offset(i))) rd_d = rld_word[i];
      if (bus_addr == ADDR_W'(count_offset(i)))  rd_d = cnt_word[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end

  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (rst)
    (|(flag_q & ien_q)) |=> irq); // R7

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|(flag_q & ien_q)) |=> !irq); // R7
endmodule

// File: tb/test_tmr_bank.sv
module test_tmr_bank;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  tmr_bank i_tmr_bank (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(6'h00, v); chk("R1 ctrl", v, 32'h0);
    for (int i = 0; i < 4; i++) begin
      rd(6'(8 + 8*i), v); chk("R1 count", v, 32'h0);
      rd(6'(4 + 8*i), v); chk("R1 reload", v, 32'h0);
    end
  endtask

  task automatic t_ctrl_fields;
    logic [31:0] v;
    wr(6'h00, 32'hFDFD_FDFD);
    rd(6'h00, v); chk("R2 fields readback, reserved zero", v, 32'h1C1C_1C1C);
    wr(6'h00, 32'h0000_0000);
    rd(6'h00, v); chk("R2 cleared", v, 32'h0);
  endtask

  task automatic t_regs_width;
    logic [31:0] v;
    wr(6'h04, 32'h1234_5678);
    rd(6'h04, v); chk("R9 narrow reload upper ignored", v, 32'h0000_5678);
    rd(6'h08, v); chk("R5 reload write loads count", v, 32'h0000_5678);
    wr(6'h14, 32'hDEAD_BEEF);
    rd(6'h14, v); chk("R10 R9 wide reload full width", v, 32'hDEAD_BEEF);
    rd(6'h18, v); chk("R8 wide count at 0x18", v, 32'hDEAD_BEEF);
    wr(6'h08, 32'h0000_1111);
    rd(6'h08, v); chk("R8 count write ignored", v, 32'h0000_5678);
    repeat (50) @(negedge clk);
    rd(6'h08, v); chk("R4 disabled timer holds", v, 32'h0000_5678);
  endtask

  task automatic t_rates;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] prev;
      int n;
      int gap;
      wr(6'h14, 32'd1000);
      wr(6'h00, 32'(2 | (k << 3)) << 16);
      bus_addr = 6'h18;
      @(negedge clk); @(negedge clk);
      prev = bus_rdata;
      n = 0;
      while (bus_rdata == prev && n < 100) begin @(negedge clk); n++; end
      prev = bus_rdata;
      gap = 0;
      while (bus_rdata == prev && gap < 100) begin @(negedge clk); gap++; end
      chk("R3 step interval", 32'(gap), 32'(2 << k));
      wr(6'h00, 32'h0);
    end
  endtask

  task automatic t_expiry;
    logic [31:0] v;
    logic [31:0] prev;
    int n;
    int gap;
    wr(6'h04, 32'd3);
    wr(6'h00, 32'h0000_0002);
    bus_addr = 6'h08;
    @(negedge clk); @(negedge clk);
    n = 0;
    prev = bus_rdata;
    while (!(prev == 32'd0 && bus_rdata == 32'd3) && n < 100) begin
      prev = bus_rdata; @(negedge clk); n++;
    end
    chk("R5 wraps from 0 to reload", bus_rdata, 32'd3);
    gap = 0;
    prev = bus_rdata;
    @(negedge clk); gap++;
    while (!(prev == 32'd0 && bus_rdata == 32'd3) && gap < 100) begin
      prev = bus_rdata; @(negedge clk); gap++;
    end
    chk("R5 period R+1 ticks", 32'(gap), 32'd8);
    rd(6'h00, v); chk("R5 flag set on expiry", v & 32'h1, 32'h1);
    chk("R7 no irq without enable", {31'b0, irq}, 32'h0);
    wr(6'h00, 32'h0000_0000);
    rd(6'h00, v); chk("R6 write 0 keeps flag", v, 32'h0000_0001);
    rd(6'h08, prev);
    repeat (20) @(negedge clk);
    rd(6'h08, v); chk("R4 holds after disable", v, prev);
    wr(6'h00, 32'h0000_0001);
    rd(6'h00, v); chk("R6 write 1 clears flag", v, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    int n;
    wr(6'h1C, 32'd5);
    wr(6'h00, 32'h0600_0000);
    n = 0;
    while (!irq && n < 100) begin @(negedge clk); n++; end
    chk("R7 irq raised", {31'b0, irq}, 32'h1);
    wr(6'h00, 32'h0400_0000);
    rd(6'h00, v); chk("R7 flag of timer 3", v, 32'h0500_0000);
    repeat (10) @(negedge clk);
    chk("R7 irq level held", {31'b0, irq}, 32'h1);
    wr(6'h00, 32'h0500_0000);
    repeat (3) @(negedge clk);
    chk("R7 irq drops after clear", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_ctrl_fields;
    t_regs_width;
    t_rates;
    t_expiry;
    t_irq;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule